// File: doc/BRIEF.md
# Register-Programmed SPI Command Engine

This block is a host-side SPI master. Software fills a small bank of eight byte-wide registers: an opcode, up to three address bytes and one optional data byte. It then writes a control register that starts a transaction. Each transaction has 1, 2, 4 or 5 outgoing bytes followed by 0 to 3 incoming bytes. The engine drives the serial clock, chip-select and the master-out line, samples the master-in line, and stores the received bytes in readback registers. Software polls the busy flag in the control register to see when the transaction has finished.

The outgoing byte count is chosen by a 2-bit code, not a count. The address bytes sit in the register bank in the reverse of their wire order. The serial clock runs at one of two rates set at start, each a parameterised number of system clocks per half period.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, busy is 0, and all eight register offsets read as 0x00.
- R2: A write to offset 0 while idle starts a transaction only when bits 6:4 of the written value are 3'b100 or 3'b101. From the next clock, bit 7 of an offset-0 read is 1 (busy), and bits 6:0 read back as written. A write to offset 0 with any other value in bits 6:4 is stored but starts nothing.
- R3: Control bits 1:0 select the outgoing bytes. Code 0 sends the opcode (offset 1) only. Code 1 sends the opcode then the data byte (offset 7). Code 2 sends the opcode then three address bytes. Code 3 sends the opcode, the three address bytes, then the data byte.
- R4: The address bytes go out as offset 4 first, then offset 3, then offset 2, so offset 4 holds the most significant address byte.
- R5: Control bits 3:2 give the number of incoming bytes, 0 to 3. During each incoming byte the engine sends 0x00. Incoming byte k (counting from 0) is stored at offset 5+k once busy clears.
- R6: The link uses SPI mode 0 with the most significant bit first. sck idles at 0. mosi holds steady while sck is high. miso is sampled on the rising edge of sck.
- R7: Control bit 4 selects the serial clock rate. With bit 4 = 0, each sck half period lasts SLOW_HALF system clocks. With bit 4 = 1, it lasts FAST_HALF system clocks. The defaults are 4 and 2.
- R8: cs_n stays 0 from the start of a transaction until after the last bit of the last byte. busy reads 1 in the first clock after cs_n rises and 0 in the clock after that.
- R9: Any register write made while busy is ignored, including a second start written to offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one clock per write |
| reg_addr | input | 3 | Register offset for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip-select |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
A start write is taken at the rising clock edge inside the write cycle, so busy reads 1 at the falling edge that ends that write. The bench checks it there. The end of a transaction is timed from the rising edge of cs_n. At the next falling clock edge busy must still be 1, and at the falling edge one clock later it must be 0. The received bytes and the stored registers are read only after that. A bench model of the device captures mosi on sck rising edges and moves miso on sck falling edges. It times the first two sck rising edges to check the selected half period. All register reads are sampled 1 ns after a falling clock edge.

// File: rtl/spi_cmd_pkg.sv
// Shared constants, state type and length decode for the SPI command engine.
// Assumes an 8-entry byte register bank addressed by a 3-bit offset.
package spi_cmd_pkg;

    localparam int REG_N  = 8;
    localparam int REG_AW = $clog2(REG_N);

    // Offsets whose position the sequencer decodes
    localparam logic [REG_AW-1:0] OFS_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] OFS_OPC    = 3'd1;
    localparam logic [REG_AW-1:0] OFS_ADR_HI = 3'd4;
    localparam logic [REG_AW-1:0] OFS_RX0    = 3'd5;
    localparam logic [REG_AW-1:0] OFS_DATA   = 3'd7;

    // Control bits 6:4 values that launch a transaction
    localparam logic [2:0] GO_SLOW = 3'b100;
    localparam logic [2:0] GO_FAST = 3'b101;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_WAIT,
        SQ_CLOSE
    } seq_state_t;

    // Number of outgoing bytes for a 2-bit length code
    function automatic logic [3:0] out_bytes(input logic [1:0] code);
        case (code)
            2'd0:    out_bytes = 4'd1;
            2'd1:    out_bytes = 4'd2;
            2'd2:    out_bytes = 4'd4;
            default: out_bytes = 4'd5;
        endcase
    endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
// Byte register bank. Offset 0 is control, and reads return busy in bit 7.
// Host writes are blocked while busy. Received bytes are written from
// offset 5 upward. Assumes reg_wr is a single-clock strobe.
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic [REG_AW-1:0]            reg_addr,
    input  logic [7:0]                   reg_wdata,
    output logic [7:0]                   reg_rdata,
    input  logic                         busy,
    input  logic                         rx_we,
    input  logic [1:0]                   rx_idx,
    input  logic [7:0]                   rx_byte,
    output logic                         start,
    output logic [REG_N-1:0][7:0]        regs_o
);

    logic [7:0]        bytes_q [REG_N];
    logic              host_we;
    logic [REG_AW-1:0] rx_ofs;

    assign host_we = reg_wr && !busy;
    assign rx_ofs  = OFS_RX0 + REG_AW'(rx_idx);

    // Launch pulse: idle control write carrying a start code
    assign start = host_we && (reg_addr == OFS_CTRL) &&
                   ((reg_wdata[6:4] == GO_SLOW) || (reg_wdata[6:4] == GO_FAST));

    for (genvar gi = 0; gi < REG_N; gi++) begin : g_byte
        // One byte: host write when idle, else captured receive data
        always_ff @(posedge clk) begin
            if (!rst_n)
                bytes_q[gi] <= 8'h00;
            else if (host_we && (reg_addr == REG_AW'(gi)))
                bytes_q[gi] <= reg_wdata;
            else if (rx_we && (rx_ofs == REG_AW'(gi)))
                bytes_q[gi] <= rx_byte;
        end
    end

    // Flatten the bank for the sequencer
    always_comb begin
        for (int i = 0; i < REG_N; i++) regs_o[i] = bytes_q[i];
    end

    // Read mux with busy substituted into control bit 7
    always_comb begin
        if (reg_addr == OFS_CTRL)
            reg_rdata = {busy, bytes_q[0][6:0]};
        else
            reg_rdata = bytes_q[reg_addr];
    end

    assert_ctrl_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && reg_wr |=> $stable(bytes_q[0]));
    assert_opc_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && reg_wr |=> $stable(bytes_q[1]));
    assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

endmodule

// File: rtl/spi_cmd_shifter.sv
// Single-byte SPI mode 0 shifter, MSB first. A go pulse loads a byte,
// and done pulses once eight bits have been exchanged. rx_byte is valid
// from the clock after done. The half period is picked by fast.
// Assumes go arrives only while the shifter is inactive.
module spi_cmd_shifter #(
    parameter int SLOW_HALF = 4,
    parameter int FAST_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       fast,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);

    localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CW   = $clog2(MAXH + 1);

    logic          active;
    logic [CW-1:0] cnt;
    logic [CW-1:0] half_lim;
    logic [2:0]    bitn;
    logic [7:0]    sh;
    logic          rx_bit;

    // Rate select: collapse to a constant when both ratios match
    if (SLOW_HALF == FAST_HALF) begin : g_one_rate
        assign half_lim = CW'(SLOW_HALF);
    end else begin : g_two_rate
        assign half_lim = fast ? CW'(FAST_HALF) : CW'(SLOW_HALF);
    end

    // Half-period timing, edge generation and shared tx/rx shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            bitn   <= 3'd0;
            sck    <= 1'b0;
            sh     <= 8'h00;
            rx_bit <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                cnt    <= '0;
                bitn   <= 3'd0;
                sck    <= 1'b0;
                sh     <= tx_byte;
            end else if (active) begin
                if (cnt == half_lim - 1'b1) begin
                    cnt <= '0;
                    if (!sck) begin
                        sck    <= 1'b1;
                        rx_bit <= miso;
                    end else begin
                        sck  <= 1'b0;
                        sh   <= {sh[6:0], rx_bit};
                        bitn <= bitn + 3'd1;
                        if (bitn == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign mosi    = sh[7];
    assign rx_byte = sh;

    assert_sck_low_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sck);
    assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));

endmodule

// File: rtl/spi_cmd_seq.sv
// Transaction sequencer. It lowers chip-select, feeds the shifter one
// byte at a time in wire order (opcode, address high to low, data, then
// 0x00 fillers for reads), and routes received bytes to the register bank.
// After the last byte it raises chip-select and drops busy one clock later.
// Assumes control and data registers stay fixed while busy.
module spi_cmd_seq
    import spi_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [REG_N-1:0][7:0] regs,
    input  logic                  done,
    input  logic [7:0]            rx_byte,
    output logic                  busy,
    output logic                  cs_n,
    output logic                  go,
    output logic                  fast,
    output logic [7:0]            tx_byte,
    output logic                  rx_we,
    output logic [1:0]            rx_idx,
    output logic [7:0]            rx_data
);

    seq_state_t st;
    logic [3:0] pos;
    logic [3:0] out_n;
    logic [3:0] in_n;
    logic [3:0] tot;
    logic [1:0] code;

    assign code  = regs[OFS_CTRL][1:0];
    assign out_n = out_bytes(code);
    assign in_n  = {2'b00, regs[OFS_CTRL][3:2]};
    assign tot   = out_n + in_n;
    assign fast  = regs[OFS_CTRL][4];
    assign busy  = (st != SQ_IDLE);
    assign go    = (st == SQ_LOAD);

    // Byte selection for the current wire position
    always_comb begin
        tx_byte = 8'h00;
        if (pos == 4'd0)
            tx_byte = regs[OFS_OPC];
        else if (pos < out_n) begin
            if (code == 2'd1 || pos == 4'd4)
                tx_byte = regs[OFS_DATA];
            else
                tx_byte = regs[REG_AW'(4'(OFS_ADR_HI) + 4'd1 - pos)];
        end
    end

    // Receive routing during the read phase
    assign rx_we   = (st == SQ_WAIT) && done && (pos >= out_n);
    assign rx_idx  = 2'(pos - out_n);
    assign rx_data = rx_byte;

    // State, byte position and chip-select control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SQ_IDLE;
            pos  <= 4'd0;
            cs_n <= 1'b1;
        end else begin
            case (st)
                SQ_IDLE: if (start) begin
                    st   <= SQ_LOAD;
                    pos  <= 4'd0;
                    cs_n <= 1'b0;
                end
                SQ_LOAD: st <= SQ_WAIT;
                SQ_WAIT: if (done) begin
                    if (pos == tot - 4'd1) begin
                        st   <= SQ_CLOSE;
                        cs_n <= 1'b1;
                    end else begin
                        pos <= pos + 4'd1;
                        st  <= SQ_LOAD;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assert_cs_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> !busy);
    assert_cs_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_LOAD || st == SQ_WAIT) |-> !cs_n);
    assert_rx_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> (4'(rx_idx) < in_n));
    assert_start_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/spi_cmd_engine.sv
// Top of the register-programmed SPI command engine. It wires the register
// bank, the transaction sequencer and the byte shifter together. SLOW_HALF
// and FAST_HALF set the sck half period in system clocks for each rate.
module spi_cmd_engine #(
    parameter int SLOW_HALF = 4,
    parameter int FAST_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sck,
    output logic       cs_n,
    output logic       mosi,
    input  logic       miso
);
    import spi_cmd_pkg::*;

    logic                  busy;
    logic                  start;
    logic [REG_N-1:0][7:0] regs;
    logic                  rx_we;
    logic [1:0]            rx_idx;
    logic [7:0]            rx_data;
    logic                  go;
    logic                  fast;
    logic [7:0]            tx_byte;
    logic                  done;
    logic [7:0]            sh_rx;

    spi_cmd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_data),
        .start(start), .regs_o(regs)
    );

    spi_cmd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .regs(regs), .done(done),
        .rx_byte(sh_rx), .busy(busy), .cs_n(cs_n), .go(go), .fast(fast),
        .tx_byte(tx_byte), .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(rx_data)
    );

    spi_cmd_shifter #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(go), .fast(fast), .tx_byte(tx_byte),
        .miso(miso), .sck(sck), .mosi(mosi), .done(done), .rx_byte(sh_rx)
    );

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sck));

endmodule

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;

    localparam int SLOW_H = 4;
    localparam int FAST_H = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sck, cs_n, mosi, miso;

    int n_chk = 0;
    int n_fail = 0;

    // Device model state
    int         bitc = 0;
    int         mi = 0;
    logic [7:0] cap [8];
    logic [7:0] stx [8];
    time        t0, t1;

    always #4 clk = ~clk;

    spi_cmd_engine #(.SLOW_HALF(SLOW_H), .FAST_HALF(FAST_H)) u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck),
        .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // Device: capture mosi on rising sck, record edge times
    always @(posedge sck) begin
        if (bitc == 0) t0 = $time;
        if (bitc == 1) t1 = $time;
        if (bitc < 64) cap[bitc / 8] = {cap[bitc / 8][6:0], mosi};
        bitc = bitc + 1;
    end

    // Device: advance miso after falling sck
    always @(negedge sck) mi = bitc;

    assign miso = (mi < 64) ? stx[mi / 8][7 - (mi % 8)] : 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic int exp_outn(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 5;
        endcase
    endfunction

    // Expected wire byte at an outgoing position (R3, R4)
    function automatic logic [7:0] exp_out(input int code, input int pos,
        input logic [7:0] opc, input logic [7:0] ahi, input logic [7:0] amid,
        input logic [7:0] alo, input logic [7:0] dat);
        if (pos == 0) return opc;
        if (code == 1) return dat;
        case (pos)
            1: return ahi;
            2: return amid;
            3: return alo;
            default: return dat;
        endcase
    endfunction

    task automatic run_xfer(input int code, input int nin, input bit fast, input bit poke);
        logic [7:0] opc, ahi, amid, alo, dat, ctl, rv;
        int outn, tot;
        opc = 8'($urandom); ahi = 8'($urandom); amid = 8'($urandom);
        alo = 8'($urandom); dat = 8'($urandom);
        outn = exp_outn(code);
        tot = outn + nin;
        for (int p = 0; p < 8; p++) begin
            stx[p] = 8'($urandom);
            cap[p] = 8'h00;
        end
        wr(3'd1, opc); wr(3'd4, ahi); wr(3'd3, amid); wr(3'd2, alo); wr(3'd7, dat);
        bitc = 0; mi = 0;
        ctl = {1'b0, 2'b10, fast, 2'(nin), 2'(code)};
        wr(3'd0, ctl);
        #1 check("R2 busy after start", int'(reg_rdata[7]) & int'(reg_addr == 3'd0), 1);
        check("R8 cs_n low in transaction", int'(cs_n), 0);
        if (poke) begin
            wr(3'd1, ~opc);
            wr(3'd0, {1'b0, 3'b101, 4'b0000});
        end
        @(posedge cs_n);
        @(negedge clk);
        #1 check("R8 busy one clock after cs_n rise", int'(reg_rdata[7]), 1);
        check("R8 bit count under cs_n", bitc, 8 * tot);
        @(negedge clk);
        #1 check("R8 busy cleared", int'(reg_rdata[7]), 0);
        for (int p = 0; p < tot; p++) begin
            if (p < outn)
                check("R3/R4 outgoing byte", int'(cap[p]),
                      int'(exp_out(code, p, opc, ahi, amid, alo, dat)));
            else
                check("R5 filler byte during read", int'(cap[p]), 0);
        end
        check("R7 sck period", int'((t1 - t0) / 8), fast ? 2 * FAST_H : 2 * SLOW_H);
        for (int k = 0; k < nin; k++) begin
            rd(3'(5 + k), rv);
            check("R5 received byte", int'(rv), int'(stx[outn + k]));
        end
        if (poke) begin
            rd(3'd1, rv);
            check("R9 opcode write while busy ignored", int'(rv), int'(opc));
            rd(3'd0, rv);
            check("R9 control write while busy ignored", int'(rv), int'(ctl));
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        void'($urandom(32'd2024));
        for (int p = 0; p < 8; p++) stx[p] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        check("R1 cs_n after reset", int'(cs_n), 1);
        check("R1 sck after reset", int'(sck), 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), rv);
            check("R1 register reset value", int'(rv), 0);
        end
        // R2 non-start control value
        wr(3'd0, 8'h32);
        repeat (20) @(negedge clk);
        check("R2 no start for other code, cs_n", int'(cs_n), 1);
        rd(3'd0, rv);
        check("R2 control stored, not busy", int'(rv), 32'h32);
        // Directed corner cases: every length code with no and full reads
        for (int c = 0; c < 4; c++) begin
            run_xfer(c, 0, 1'b0, 1'b0);
            run_xfer(c, 3, 1'b1, 1'b0);
        end
        run_xfer(3, 3, 1'b0, 1'b1);
        run_xfer(0, 1, 1'b1, 1'b1);
        // Random mix
        for (int i = 0; i < 24; i++)
            run_xfer(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
                     1'($urandom), 1'($urandom));
        check("R6 sck idle low at end", int'(sck), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule